// File: doc/BRIEF.md
# Bouncing Up/Down Sweep Counter with One-Hot Decoder

This block is a small counter that sweeps back and forth between a low endpoint (0) and a high endpoint (5). It does not wrap. A 4-bit count register moves one step on each cycle in which the `tick` enable is high. The `tick` enable stands in for a slow count clock on the common system clock.

The low three bits of the count drive a 3-to-8 decoder. The decoder outputs are active-low, and exactly one line is low at any time. The eight lines appear on the `dec_n` bus. Two of these lines also steer a set/clear direction latch:
- Decode line 5 going low sets the direction to down.
- Decode line 0 going low clears the direction to up.

The latch reacts combinationally, in the same cycle the count lands on an endpoint. The next tick therefore always moves away from that endpoint.

An external synchronous reset is stretched internally. The counter is held at zero while `rst` is high and for a fixed number of cycles (default 40) after `rst` is released. While the count is zero, decode line 0 is low, and that low line resolves the direction latch to up.

Top module: `bounce_sweep`

## Requirements
- R1: While `rst` is high, and for the 40 clock cycles after it is sampled low, `count` is 0, `dir_down` is 0 and `dec_n` is 8'hFE.
- R2: A `tick` in any of those 40 hold cycles has no effect on `count`. A `tick` in the 41st cycle after release moves `count` from 0 to 1.
- R3: With `dir_down` = 0, a cycle with `tick` = 1 raises `count` by one in the following cycle. A cycle with `tick` = 0 leaves `count` unchanged.
- R4: With `dir_down` = 1, a cycle with `tick` = 1 lowers `count` by one in the following cycle.
- R5: `dec_n[i]` is 0 exactly when `count[2:0]` equals i, and it is 1 otherwise. Exactly one bit of `dec_n` is low, so `dec_n` equals the bitwise inverse of (1 << `count[2:0]`).
- R6: In any cycle where `count` is 5, `dir_down` is 1 in that same cycle.
- R7: In any cycle where `count` is 0, `dir_down` is 0 in that same cycle.
- R8: While `count` is between 1 and 4, `dir_down` keeps the value it had in the previous cycle.
- R9: Under continued ticking, `count` follows 0,1,2,3,4,5,4,3,2,1,0,1,… and never leaves the range 0 to 5. As a result, `dec_n[7:6]` stays 2'b11.
- R10: Asserting `rst` in the middle of a sweep returns `count` to 0 and `dir_down` to 0 on the next cycle. The 40-cycle hold of R1 and R2 then applies again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, stretched internally |
| tick | input | 1 | Single-cycle count enable (slow count clock) |
| count | output | 4 | Current count value |
| dir_down | output | 1 | Direction latch: 0 counts up, 1 counts down |
| dec_n | output | 8 | Active-low one-hot decode of count[2:0] |

## Verification
The decision that flips direction at an endpoint and the counter step that follows it can fall in the same cycle. This happens when a tick arrives in the very cycle the count sits on 0 or 5. The bench provokes this by supplying back-to-back ticks across both turnarounds, both in a fixed vector table and in a long run with irregular tick gaps. It judges the result by checking three things:
- the count after an endpoint steps back inward, never to 6 and never wrapping to 15;
- `dir_down` already reads the new value in the endpoint cycle;
- the decode bus has exactly one low line.

A second overlap, the end of the reset hold coinciding with a tick, is checked by holding `tick` high through the whole hold window.

// File: rtl/bounce_pkg.sv
package bounce_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

endpackage

// File: rtl/bounce_rst_hold.sv
module bounce_rst_hold #(
  parameter int HOLD = 40
) (
  input  logic clk,
  input  logic rst,
  output logic rst_int
);

  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= HW'(HOLD);
    end else if (left_q != '0) begin
      left_q <= left_q - HW'(1);
    end
  end

  assign rst_int = rst | (left_q != '0);

endmodule

// File: rtl/bounce_decoder.sv
module bounce_decoder #(
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0]      sel,
  output logic [(1<<SEL_W)-1:0] line_n
);

  localparam int LINES = 1 << SEL_W;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign line_n[i] = (sel != SEL_W'(i));
  end

endmodule

// File: rtl/bounce_dir_latch.sv
module bounce_dir_latch
  import bounce_pkg::*;
(
  input  logic clk,
  input  logic rst_int,
  input  logic set_n,
  input  logic clr_n,
  output dir_e dir
);

  dir_e dir_q;
  dir_e dir_now;

  always_comb begin
    if (!set_n) begin
      dir_now = DIR_DOWN;
    end else if (!clr_n) begin
      dir_now = DIR_UP;
    end else begin
      dir_now = dir_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_int) begin
      dir_q <= DIR_UP;
    end else begin
      dir_q <= dir_now;
    end
  end

  assign dir = dir_now;

endmodule

// File: rtl/bounce_counter.sv
module bounce_counter
  import bounce_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_int,
  input  logic             tick,
  input  dir_e             dir,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst_int) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (dir == DIR_DOWN) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/bounce_sweep.sv
module bounce_sweep
  import bounce_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int SEL_W    = 3,
  parameter int TOP      = 5,
  parameter int BOTTOM   = 0,
  parameter int RST_HOLD = 40
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  output logic [CNT_W-1:0]      count,
  output logic                  dir_down,
  output logic [(1<<SEL_W)-1:0] dec_n
);

  localparam int LINES = 1 << SEL_W;

  logic rst_int;
  dir_e dir;

  bounce_rst_hold #(.HOLD(RST_HOLD)) u_rst (
    .clk     (clk),
    .rst     (rst),
    .rst_int (rst_int)
  );

  bounce_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_int (rst_int),
    .tick    (tick),
    .dir     (dir),
    .count   (count)
  );

  logic [LINES-1:0] line_n;

  bounce_decoder #(.SEL_W(SEL_W)) u_dec (
    .sel    (count[SEL_W-1:0]),
    .line_n (line_n)
  );

  bounce_dir_latch u_dir (
    .clk     (clk),
    .rst_int (rst_int),
    .set_n   (line_n[TOP]),
    .clr_n   (line_n[BOTTOM]),
    .dir     (dir)
  );

  assign dec_n    = line_n;
  assign dir_down = (dir == DIR_DOWN);

endmodule

// File: rtl/bounce_sweep_chk.sv
module bounce_sweep_chk #(
  parameter int CNT_W  = 4,
  parameter int LINES  = 8,
  parameter int TOP    = 5,
  parameter int BOTTOM = 0
) (
  input logic             clk,
  input logic             rst_int,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic             dir_down,
  input logic [LINES-1:0] dec_n
);

  logic held_q = 1'b0;

  always_ff @(posedge clk) held_q <= rst_int;

  always @(negedge clk) begin
    if (held_q) begin
      AST_HOLD_ZERO: assert (count == '0 && !dir_down); // R1
    end
  end

  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst_int)
    (tick && !dir_down) |=> (count == $past(count) + CNT_W'(1))); // R3

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst_int)
    (!tick) |=> $stable(count)); // R3

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst_int)
    (tick && dir_down) |=> (count == $past(count) - CNT_W'(1))); // R4

  AST_ONE_LOW: assert property (@(posedge clk) disable iff (rst_int)
    $countones(~dec_n) == 1); // R5

  AST_TOP_TURN: assert property (@(posedge clk) disable iff (rst_int)
    (count == CNT_W'(TOP)) |-> dir_down); // R6

  AST_BOTTOM_TURN: assert property (@(posedge clk) disable iff (rst_int)
    (count == CNT_W'(BOTTOM)) |-> !dir_down); // R7

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst_int)
    (count != CNT_W'(TOP) && count != CNT_W'(BOTTOM)) |-> (dir_down == $past(dir_down))); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst_int)
    count <= CNT_W'(TOP)); // R9

  AST_HIGH_LINES: assert property (@(posedge clk) disable iff (rst_int)
    dec_n[LINES-1:TOP+1] == '1); // R9

endmodule

bind bounce_sweep bounce_sweep_chk #(
  .CNT_W  (CNT_W),
  .LINES  (1 << SEL_W),
  .TOP    (TOP),
  .BOTTOM (BOTTOM)
) u_chk (
  .clk      (clk),
  .rst_int  (rst_int),
  .tick     (tick),
  .count    (count),
  .dir_down (dir_down),
  .dec_n    (dec_n)
);

// File: tb/sim_bounce_sweep.sv
`timescale 1ns/1ps
module sim_bounce_sweep;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [3:0] count;
  logic       dir_down;
  logic [7:0] dec_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bounce_sweep u0 (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .count    (count),
    .dir_down (dir_down),
    .dec_n    (dec_n)
  );

  // {tick, expected dir_down, expected count}
  localparam int NV = 19;
  localparam logic [5:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd1}, {1'b1, 1'b0, 4'd2}, {1'b0, 1'b0, 4'd2},
    {1'b1, 1'b0, 4'd3}, {1'b1, 1'b0, 4'd4}, {1'b1, 1'b1, 4'd5},
    {1'b0, 1'b1, 4'd5}, {1'b1, 1'b1, 4'd4}, {1'b1, 1'b1, 4'd3},
    {1'b1, 1'b1, 4'd2}, {1'b1, 1'b1, 4'd1}, {1'b1, 1'b0, 4'd0},
    {1'b0, 1'b0, 4'd0}, {1'b1, 1'b0, 4'd1}, {1'b1, 1'b0, 4'd2},
    {1'b1, 1'b0, 4'd3}, {1'b1, 1'b0, 4'd4}, {1'b1, 1'b1, 4'd5},
    {1'b1, 1'b1, 4'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dec_exp(input logic [3:0] c);
    return ~(8'd1 << c[2:0]);
  endfunction

  task automatic check_state(input string req, input logic [3:0] c, input logic d);
    chk(req, {28'd0, count}, {28'd0, c});
    chk(req, {31'd0, dir_down}, {31'd0, d});
    chk({req, " R5"}, {24'd0, dec_n}, {24'd0, dec_exp(c)});
  endtask

  task automatic hold_window(input string req);
    // release at a negedge with tick held high through the 40 hold cycles
    rst  = 1'b0;
    tick = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check_state(req, 4'd0, 1'b0);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] m_cnt;
    logic       m_dir;

    repeat (3) @(negedge clk);
    check_state("R1 in reset", 4'd0, 1'b0);

    hold_window("R2 hold tick ignored");

    // R2: 41st cycle tick counts; vector walk covers R3 R4 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      tick = VEC[v][5];
      @(negedge clk);
      check_state($sformatf("R3 R4 R6 R7 vector %0d", v), VEC[v][3:0], VEC[v][4]);
    end

    // long run against a model derived from the requirements: R9 and R8
    m_cnt = 4'd4;
    m_dir = 1'b1;
    for (int i = 0; i < 300; i++) begin
      tick = (i % 3) != 2;
      @(negedge clk);
      if (tick) begin
        m_cnt = m_dir ? m_cnt - 4'd1 : m_cnt + 4'd1;
        if (m_cnt == 4'd5) m_dir = 1'b1;
        else if (m_cnt == 4'd0) m_dir = 1'b0;
      end
      check_state("R9 sweep", m_cnt, m_dir);
      chk("R9 range", {31'd0, count <= 4'd5}, 32'd1);
      chk("R9 lines 6 7", {30'd0, dec_n[7:6]}, 32'd3);
    end

    // R10: reset in the middle, heading down from 5 toward 3
    while (!(count == 4'd3 && dir_down)) begin
      tick = 1'b1;
      @(negedge clk);
    end
    rst  = 1'b1;
    tick = 1'b1;
    @(negedge clk);
    check_state("R10 mid reset", 4'd0, 1'b0);
    @(negedge clk);
    check_state("R10 mid reset held", 4'd0, 1'b0);
    hold_window("R10 hold again");
    tick = 1'b1;
    @(negedge clk);
    check_state("R10 first count after hold", 4'd1, 1'b0);
    tick = 1'b0;
    @(negedge clk);
    check_state("R3 no tick", 4'd1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule